// File: doc/BRIEF.md
# Serial Register Read Responder

This block is the slave side of a four-wire serial link for a small file of 9-bit registers. It uses clock polarity 0, phase 0. A host holds chip select low and sends a 16-bit frame, most significant bit first. The frame starts with a 4-bit address and a 2-bit command. The block answers on its serial output with a one-bit status flag and then the nine bits of the addressed register. Only the read command is handled. The register contents come in as a flat parallel bus from the surrounding logic.

Some addresses are marked non-volatile by a parameter. While the external non-volatile write-busy input is high, a read of any of those locations is refused. The refusal shows as a low flag bit and nine zero data bits. A status location reports the busy input, so the host can poll for the end of a write. A second parameter mask lists the implemented addresses. A read of an address outside that mask is also refused.

The serial clock, chip select and serial input are sampled by the system clock `clk_i`. They are taken as already synchronous to it, and the serial clock must run well below half the rate of `clk_i`.

Top module: `spi_reg_read_resp`

## Requirements
- R1: A frame is shifted in most significant bit first. Each bit is taken from `sdi_i` on a rising `sck_i` edge while `cs_ni` is low. Bits 1..4 form the address, with the first bit as the address MSB. Bits 5..6 form the command, and `2'b11` means read.
- R2: Before each of the first six rising edges of a frame, `sdo_o` is 1.
- R3: Before the 7th rising edge, `sdo_o` carries the flag bit. The flag is 1 when the read is accepted and 0 when it is refused.
- R4: Before rising edges 8 to 16, `sdo_o` carries bits 8 down to 0 of the addressed register. For register `a`, those bits are `regs_i[a*9 +: 9]`.
- R5: A command other than `2'b11`, or an address whose bit in `IMPL_MASK` is 0, is refused. A refusal gives a flag of 0 and nine data bits of 0. By default only addresses 0..5 are implemented.
- R6: A read of an address whose bit in `NV_MASK` is set, made while `nv_busy_i` is 1, is refused in the same way. Reads of volatile addresses are still accepted. By default the non-volatile addresses are 2, 3 and 5..15.
- R7: Address `STATUS_ADDR` (default 4) returns `nv_busy_i` at data bit `BUSY_POS` (default 4) and 0 in every other bit. Its `regs_i` slot is ignored. The status register is volatile.
- R8: While `cs_ni` is high, `sdo_o` is 1 and the frame state is cleared. A frame cut short by raising `cs_ni` leaves no trace, so the next frame is decoded from its own first bit.
- R9: After the 16th rising edge, `sdo_o` returns to 1 and stays at 1 for any further serial clocks in the same frame. The `sdi_i` bits from the 7th onward have no effect.
- R10: `sdo_o` changes only after a falling `sck_i` edge or after `cs_ni` rises. It never changes on a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock, idle low |
| sdi_i | input | 1 | Serial data from the host |
| nv_busy_i | input | 1 | Non-volatile write in progress |
| regs_i | input | 144 | Register contents, 16 entries of 9 bits, entry a at bits a*9 +: 9 |
| sdo_o | output | 1 | Serial data to the host |

## Verification
Every address from 0 to 15 is read with the busy input low and again with it high. This separates implemented from unimplemented locations, and volatile from non-volatile locations under a write. The status location is read in both busy states, to show the busy bit at its position and that the `regs_i` slot is not used. The three non-read command codes are sent to a valid address, to show that the refusal comes from the command field and not from the address. Random frames with random register contents and random don't-care tail bits exercise the data path. Directed cases cover an aborted frame followed by a clean one, and clocks past bit 16.

// File: rtl/spi_rr_pkg.sv
package spi_rr_pkg;
  localparam int ADDR_W  = 4;
  localparam int CMD_W   = 2;
  localparam int DATA_W  = 9;
  localparam int NREG    = 1 << ADDR_W;
  localparam int HDR_W   = ADDR_W + CMD_W;
  localparam int FRAME_W = HDR_W + 1 + DATA_W;
  localparam logic [CMD_W-1:0] CMD_READ = '1;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CMD_W-1:0]  cmd_t;
  typedef logic [DATA_W-1:0] data_t;
endpackage

// File: rtl/spi_rr_edge.sv
module spi_rr_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  output logic rise_o,
  output logic fall_o
);
  logic sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_i;
  end

  assign rise_o = ~cs_ni &  sck_i & ~sck_q;
  assign fall_o = ~cs_ni & ~sck_i &  sck_q;
endmodule

// File: rtl/spi_rr_decode.sv
module spi_rr_decode
  import spi_rr_pkg::*;
#(
  parameter logic [NREG-1:0] IMPL_MASK   = 16'h003F,
  parameter logic [NREG-1:0] NV_MASK     = 16'hFFEC,
  parameter int              STATUS_ADDR = 4,
  parameter int              BUSY_POS    = 4
) (
  input  addr_t                   addr_i,
  input  cmd_t                    cmd_i,
  input  logic                    busy_i,
  input  logic [NREG*DATA_W-1:0]  regs_i,
  output logic                    ok_o,
  output data_t                   data_o
);
  localparam addr_t STAT_A = addr_t'(STATUS_ADDR);

  data_t stat_word;
  data_t reg_word;

  always_comb begin
    stat_word           = '0;
    stat_word[BUSY_POS] = busy_i;
  end

  assign reg_word = regs_i[addr_i*DATA_W +: DATA_W];

  // refused on bad command, hole in the map, or NV location under write
  assign ok_o = (cmd_i == CMD_READ) && IMPL_MASK[addr_i]
              && !(NV_MASK[addr_i] && busy_i);

  always_comb begin
    if (!ok_o)                 data_o = '0;
    else if (addr_i == STAT_A) data_o = stat_word;
    else                       data_o = reg_word;
  end
endmodule

// File: rtl/spi_rr_shift.sv
module spi_rr_shift #(
  parameter int HDR_W   = 6,
  parameter int DATA_W  = 9,
  parameter int FRAME_W = 16,
  localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sdi_i,
  input  logic              ok_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [HDR_W-1:0]  hdr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              sdo_o
);
  localparam logic [CNT_W-1:0] CNT_HDR = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(FRAME_W);

  logic [CNT_W-1:0]  cnt_q;
  logic [HDR_W-1:0]  hdr_q;
  logic [DATA_W:0]   osr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hdr_q <= '0;
      osr_q <= '1;
    end else if (cs_ni) begin
      cnt_q <= '0;
      hdr_q <= '0;
      osr_q <= '1;
    end else begin
      if (rise_i && cnt_q != CNT_END) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q < CNT_HDR) hdr_q <= {hdr_q[HDR_W-2:0], sdi_i};
      end
      if (fall_i) begin
        if (cnt_q == CNT_HDR)     osr_q <= {ok_i, data_i};
        else if (cnt_q > CNT_HDR) osr_q <= {osr_q[DATA_W-1:0], 1'b1};
      end
    end
  end

  assign hdr_o = hdr_q;
  assign cnt_o = cnt_q;
  assign sdo_o = osr_q[DATA_W];
endmodule

// File: rtl/spi_reg_read_resp.sv
module spi_reg_read_resp
  import spi_rr_pkg::*;
#(
  parameter logic [NREG-1:0] IMPL_MASK   = 16'h003F,
  parameter logic [NREG-1:0] NV_MASK     = 16'hFFEC,
  parameter int              STATUS_ADDR = 4,
  parameter int              BUSY_POS    = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cs_ni,
  input  logic                   sck_i,
  input  logic                   sdi_i,
  input  logic                   nv_busy_i,
  input  logic [NREG*DATA_W-1:0] regs_i,
  output logic                   sdo_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic             sck_rise, sck_fall;
  logic [HDR_W-1:0] hdr;
  logic [CNT_W-1:0] bit_cnt;
  logic             rd_ok;
  data_t            rd_data;

  spi_rr_edge u_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck_i),
    .rise_o(sck_rise), .fall_o(sck_fall)
  );

  spi_rr_decode #(
    .IMPL_MASK(IMPL_MASK), .NV_MASK(NV_MASK),
    .STATUS_ADDR(STATUS_ADDR), .BUSY_POS(BUSY_POS)
  ) u_dec (
    .addr_i(hdr[HDR_W-1:CMD_W]), .cmd_i(hdr[CMD_W-1:0]),
    .busy_i(nv_busy_i), .regs_i(regs_i),
    .ok_o(rd_ok), .data_o(rd_data)
  );

  spi_rr_shift #(.HDR_W(HDR_W), .DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni),
    .rise_i(sck_rise), .fall_i(sck_fall), .sdi_i(sdi_i),
    .ok_i(rd_ok), .data_i(rd_data),
    .hdr_o(hdr), .cnt_o(bit_cnt), .sdo_o(sdo_o)
  );
endmodule

// File: rtl/spi_reg_read_resp_chk.sv
module spi_reg_read_resp_chk #(
  parameter int HDR_W   = 6,
  parameter int CMD_W   = 2,
  parameter int FRAME_W = 16,
  parameter int CNT_W   = 5,
  parameter logic [15:0] NV_MASK = 16'hFFEC
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_ni,
  input logic             nv_busy_i,
  input logic             sck_fall,
  input logic [HDR_W-1:0] hdr,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             sdo_o
);
  localparam logic [CNT_W-1:0] C_HDR = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] C_END = CNT_W'(FRAME_W);

  // R2
  hdr_phase_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && bit_cnt < C_HDR) |-> sdo_o);

  // R5
  bad_cmd_refused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_fall && bit_cnt == C_HDR && hdr[CMD_W-1:0] != '1) |=> !sdo_o);

  // R6
  nv_busy_refused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_fall && bit_cnt == C_HDR && nv_busy_i && NV_MASK[hdr[HDR_W-1:CMD_W]]) |=> !sdo_o);

  // R8
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni)) |-> sdo_o);

  // R8
  idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> bit_cnt == '0);

  // R9
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= C_END);

  // R10
  sdo_fall_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(sck_fall) && !$past(cs_ni) && !cs_ni) |-> $stable(sdo_o));
endmodule

bind spi_reg_read_resp spi_reg_read_resp_chk #(
  .HDR_W(HDR_W), .CMD_W(CMD_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W), .NV_MASK(NV_MASK)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .nv_busy_i(nv_busy_i),
  .sck_fall(sck_fall), .hdr(hdr), .bit_cnt(bit_cnt), .sdo_o(sdo_o)
);

// File: tb/sim_spi_reg_read_resp.sv
module sim_spi_reg_read_resp;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, nv_busy = 1'b0;
  logic [8:0] regs [16];
  logic [143:0] regs_flat;
  logic sdo;
  logic stable_bad;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb for (int i = 0; i < 16; i++) regs_flat[i*9 +: 9] = regs[i];

  spi_reg_read_resp u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi),
    .nv_busy_i(nv_busy), .regs_i(regs_flat), .sdo_o(sdo)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic [3:0] a, input logic [1:0] c, input logic busy);
    logic ok;
    logic [8:0] d;
    logic nv;
    nv = (a == 4'd2) || (a == 4'd3) || (a >= 4'd5);
    ok = (c == 2'b11) && (a <= 4'd5) && !(nv && busy);
    if (!ok)            d = '0;
    else if (a == 4'd4) d = {4'b0, busy, 4'b0};
    else                d = regs[a];
    return {6'h3F, ok, d};
  endfunction

  task automatic do_bit(input logic b, output logic got);
    @(negedge clk) sdi = b;
    repeat (2) @(negedge clk);
    got = sdo;
    sck = 1'b1;
    repeat (2) @(negedge clk);
    if (sdo !== got) stable_bad = 1'b1;
    sck = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rand_regs();
    for (int i = 0; i < 16; i++) regs[i] = 9'($urandom);
  endtask

  task automatic frame(input logic [3:0] a, input logic [1:0] c, input logic busy,
                       input int extra, input string tag);
    logic [15:0] tx, got, exp;
    logic g;
    tx = {a, c, 10'($urandom)};
    nv_busy = busy;
    stable_bad = 1'b0;
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 15; i >= 0; i--) begin
      do_bit(tx[i], g);
      got[i] = g;
    end
    exp = exp_word(a, c, busy);
    chk(got == exp, tag, 32'(got), 32'(exp));
    for (int i = 0; i < extra; i++) begin
      do_bit(1'($urandom), g);
      chk(g == 1'b1, "R9 tail", 32'(g), 32'd1);
    end
    chk(!stable_bad, "R10", 32'(stable_bad), 32'd0);
    @(negedge clk) cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sdo == 1'b1, "R8 idle", 32'(sdo), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic g;
    void'($urandom(32'd7411));
    rand_regs();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(sdo == 1'b1, "R8 reset", 32'(sdo), 32'd1);

    // R4 R5 R6: every address, busy low and high
    for (int a = 0; a < 16; a++) begin
      rand_regs();
      frame(4'(a), 2'b11, 1'b0, 0, "R1 R2 R3 R4 R5");
      frame(4'(a), 2'b11, 1'b1, 0, "R3 R5 R6");
    end
    // R7: status with its slot holding junk
    regs[4] = 9'h1FF;
    frame(4'd4, 2'b11, 1'b0, 0, "R7 idle");
    frame(4'd4, 2'b11, 1'b1, 0, "R7 busy");
    // R5: non-read commands on a valid address
    for (int c = 0; c < 3; c++) frame(4'd1, 2'(c), 1'b0, 0, "R5 cmd");
    // R9: extra clocks after bit 16
    frame(4'd0, 2'b11, 1'b0, 3, "R9 frame");

    // R8: aborted frame then clean frame
    @(negedge clk) cs_n = 1'b0;
    do_bit(1'b1, g); do_bit(1'b1, g); do_bit(1'b1, g); do_bit(1'b1, g); do_bit(1'b1, g);
    @(negedge clk) cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sdo == 1'b1, "R8 abort", 32'(sdo), 32'd1);
    frame(4'd1, 2'b11, 1'b0, 0, "R8 after abort");

    // R1 R4: random frames
    for (int n = 0; n < 150; n++) begin
      rand_regs();
      frame(4'($urandom), ((n % 4) == 0) ? 2'($urandom) : 2'b11, 1'($urandom), 0, "R1 R4 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule